// File: doc/BRIEF.md
# Hourly Chime and Streamed Note Player

This block drives a one-bit buzzer. It plays a fixed, looping 64-step melody during the first thirty seconds of every hour. It can also sound notes that arrive one at a time as byte codes from a serial receiver, each code qualified by a valid strobe.

The time digits come from an external time-of-day counter. The melody window is open only while both minute digits are zero and the seconds-tens digit is below a limit, which defaults to 3. A tone is a square wave: a counter runs up to a half-period count, and each time it gets there the buzzer output flips.

While received notes are playing, the block drops a display refresh enable so that the time and temperature readout holds still. Playback of received notes stops when no byte has arrived for a programmable idle time, which defaults to one second. The refresh enable then rises again. Received notes take priority over the hourly melody.

Top module: `chime_player`

## Requirements
- R1: A synchronous active-high `rst` clears every counter and the melody step index. While `rst` is high and after it is released, `buzzer` is 0 and `refresh_en` is 1.
- R2: The melody sounds only while `en` is 1, `min_tens` = 0, `min_ones` = 0 and `sec_tens` < 3. Whenever the window is closed, the step index returns to 0, so each opening of the window starts at step 0.
- R3: For an audible note code, `buzzer` toggles every D cycles, where D is the note's 12 MHz half-period count shifted right by `HALF_SHIFT`. The counts used are: 0x01 = 22935, 0x08 = 11464, 0x09 = 10215, 0x0F = 5740, 0x10 = 5107 and 0x15 = 3036.
- R4: The melody has 64 steps, each lasting `STEP_CYCLES` cycles, and wraps from step 63 back to step 0. Step i plays code 8 + i[2:0] when i[3] = 0, and code 15 - i[2:0] when i[3] = 1.
- R5: Received codes 0x01..0x07 select low notes 1..7, 0x08..0x0E select middle notes 1..7, and 0x0F..0x15 select high notes 1..7. Any other value, including 0x00, 0x16 and 0xFF, is silent and holds `buzzer` at 0.
- R6: From the cycle after a `rx_valid` strobe, `refresh_en` is 0 and the received code sounds.
- R7: Streamed playback ends `IDLE_CYCLES` cycles after the last strobe. At that point `refresh_en` returns to 1 and the stream no longer drives the buzzer.
- R8: While streamed playback is active, the streamed code is played even if the melody window is open.
- R9: `buzzer` is held at 0 when neither source is active, and whenever `en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Buzzer enable |
| min_tens | input | 4 | Minutes tens digit, BCD |
| min_ones | input | 4 | Minutes ones digit, BCD |
| sec_tens | input | 4 | Seconds tens digit, BCD |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received note code |
| buzzer | output | 1 | Square-wave buzzer drive, registered |
| refresh_en | output | 1 | Display update enable; 0 while streamed notes play |

## Verification
The assertions check four things on every cycle. The tone counter stays below the current half-period. A silent code leaves the buzzer low on the next cycle. The step index wraps from 63 to 0 and is zero while the window is closed. A strobe drops the refresh enable, and the idle counter stays below its limit.

The toggle intervals for particular codes can only be shown by the bench's scenarios. So can the exact cycle at which the idle timeout releases the display, the melody's pitch sequence across the wrap, the window boundary digits, and stream priority over an open window.

// File: rtl/chime_pkg.sv
package chime_pkg;

  localparam int CODE_W = 8;
  localparam int HALF_W = 16;

  // Half-period counts at 12 MHz; zero means silent.
  function automatic logic [HALF_W-1:0] note_half(input logic [CODE_W-1:0] code);
    case (code)
      8'h01: note_half = 16'd22935;
      8'h02: note_half = 16'd20428;
      8'h03: note_half = 16'd18203;
      8'h04: note_half = 16'd17181;
      8'h05: note_half = 16'd15305;
      8'h06: note_half = 16'd13635;
      8'h07: note_half = 16'd12147;
      8'h08: note_half = 16'd11464;
      8'h09: note_half = 16'd10215;
      8'h0A: note_half = 16'd9100;
      8'h0B: note_half = 16'd8589;
      8'h0C: note_half = 16'd7652;
      8'h0D: note_half = 16'd6817;
      8'h0E: note_half = 16'd6073;
      8'h0F: note_half = 16'd5740;
      8'h10: note_half = 16'd5107;
      8'h11: note_half = 16'd4549;
      8'h12: note_half = 16'd4294;
      8'h13: note_half = 16'd3825;
      8'h14: note_half = 16'd3408;
      8'h15: note_half = 16'd3036;
      default: note_half = '0;
    endcase
  endfunction

  // Melody: rising middle scale on even octets, falling on odd ones.
  function automatic logic [CODE_W-1:0] melody_code(input logic [5:0] idx);
    logic [CODE_W-1:0] low3;
    low3 = {5'd0, idx[2:0]};
    melody_code = idx[3] ? (8'd15 - low3) : (8'd8 + low3);
  endfunction

  typedef enum logic [1:0] {SRC_NONE, SRC_CHIME, SRC_STREAM} src_t;

endpackage

// File: rtl/melody_seq.sv
module melody_seq
  import chime_pkg::*;
#(
  parameter int STEP_CYCLES = 3_000_000,
  parameter int STEPS       = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              window,
  output logic [CODE_W-1:0] code
);
  localparam int STEP_W = $clog2(STEP_CYCLES);
  localparam int IDX_W  = $clog2(STEPS);

  logic [STEP_W-1:0] tick_q;
  logic [IDX_W-1:0]  step_q;
  logic              step_end;

  assign step_end = (tick_q == STEP_W'(STEP_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || !window) begin
      tick_q <= '0;
      step_q <= '0;
    end else if (step_end) begin
      tick_q <= '0;
      step_q <= (step_q == IDX_W'(STEPS - 1)) ? '0 : step_q + 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign code = melody_code(6'(step_q));

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (window && step_end && step_q == IDX_W'(STEPS - 1)) |=> (step_q == '0)); // R4

  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (rst)
    !window |=> (step_q == '0)); // R2

endmodule

// File: rtl/stream_ctrl.sv
module stream_ctrl
  import chime_pkg::*;
#(
  parameter int IDLE_CYCLES = 12_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CODE_W-1:0] rx_byte,
  output logic              active,
  output logic [CODE_W-1:0] code,
  output logic              refresh_en
);
  localparam int IDLE_W = $clog2(IDLE_CYCLES);

  logic [IDLE_W-1:0] idle_q;
  logic [CODE_W-1:0] code_q;
  logic              refresh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q    <= '0;
      code_q    <= '0;
      refresh_q <= 1'b1;
    end else if (rx_valid) begin
      idle_q    <= '0;
      code_q    <= rx_byte;
      refresh_q <= 1'b0;
    end else if (!refresh_q) begin
      if (idle_q == IDLE_W'(IDLE_CYCLES - 1)) begin
        idle_q    <= '0;
        refresh_q <= 1'b1;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign active     = !refresh_q;
  assign code       = code_q;
  assign refresh_en = refresh_q;

  AST_FREEZE_ON_RX: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !refresh_en); // R6

  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    idle_q < IDLE_W'(IDLE_CYCLES)); // R7

endmodule

// File: rtl/tone_gen.sv
module tone_gen
  import chime_pkg::*;
#(
  parameter int HALF_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic              buzzer
);
  logic [HALF_W-1:0] half_c;
  logic [HALF_W-1:0] cnt_q;
  logic [CODE_W-1:0] last_q;
  logic              buz_q;
  logic              audible;

  assign half_c  = note_half(code) >> HALF_SHIFT;
  assign audible = (half_c != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      last_q <= '0;
      buz_q  <= 1'b0;
    end else if (code != last_q) begin
      cnt_q  <= '0;
      last_q <= code;
      buz_q  <= 1'b0;
    end else if (!audible) begin
      cnt_q <= '0;
      buz_q <= 1'b0;
    end else if (cnt_q == half_c - 1'b1) begin
      cnt_q <= '0;
      buz_q <= ~buz_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign buzzer = buz_q;

  AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (rst)
    (audible && code == last_q) |-> (cnt_q < half_c)); // R3

  AST_SILENT_LOW: assert property (@(posedge clk) disable iff (rst)
    !audible |=> !buzzer); // R5

endmodule

// File: rtl/chime_player.sv
module chime_player
  import chime_pkg::*;
#(
  parameter int STEP_CYCLES    = 3_000_000,
  parameter int STEPS          = 64,
  parameter int IDLE_CYCLES    = 12_000_000,
  parameter int HALF_SHIFT     = 0,
  parameter int DIGIT_W        = 4,
  parameter int SEC_TENS_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [DIGIT_W-1:0] min_tens,
  input  logic [DIGIT_W-1:0] min_ones,
  input  logic [DIGIT_W-1:0] sec_tens,
  input  logic               rx_valid,
  input  logic [CODE_W-1:0]  rx_byte,
  output logic               buzzer,
  output logic               refresh_en
);
  logic              window;
  logic              stream_active;
  logic [CODE_W-1:0] chime_code;
  logic [CODE_W-1:0] stream_code;
  logic [CODE_W-1:0] play_code;
  src_t              src;

  assign window = en && (min_tens == '0) && (min_ones == '0) &&
                  (sec_tens < DIGIT_W'(SEC_TENS_LIMIT));

  melody_seq #(.STEP_CYCLES(STEP_CYCLES), .STEPS(STEPS)) u_melody (
    .clk(clk), .rst(rst), .window(window), .code(chime_code)
  );

  stream_ctrl #(.IDLE_CYCLES(IDLE_CYCLES)) u_stream (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .active(stream_active), .code(stream_code), .refresh_en(refresh_en)
  );

  always_comb begin
    if (!en)                src = SRC_NONE;
    else if (stream_active) src = SRC_STREAM;
    else if (window)        src = SRC_CHIME;
    else                    src = SRC_NONE;
    case (src)
      SRC_STREAM: play_code = stream_code;
      SRC_CHIME:  play_code = chime_code;
      default:    play_code = '0;
    endcase
  end

  tone_gen #(.HALF_SHIFT(HALF_SHIFT)) u_tone (
    .clk(clk), .rst(rst), .code(play_code), .buzzer(buzzer)
  );

  AST_BUZ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> !buzzer); // R9

endmodule

// File: tb/sim_chime_player.sv
module sim_chime_player;
  localparam int CLK_PERIOD = 10;
  localparam int STEP  = 1000;
  localparam int IDLE  = 1500;
  localparam int SHIFT = 6;
  localparam int LIMIT = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic [3:0] min_tens = 4'd1, min_ones = 4'd0, sec_tens = 4'd0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic buzzer, refresh_en;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chime_player #(.STEP_CYCLES(STEP), .IDLE_CYCLES(IDLE), .HALF_SHIFT(SHIFT)) u0 (
    .clk(clk), .rst(rst), .en(en), .min_tens(min_tens), .min_ones(min_ones),
    .sec_tens(sec_tens), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .buzzer(buzzer), .refresh_en(refresh_en)
  );

  // Stimulus/expected table: {code, 12 MHz half-period count (0 = silent)}
  localparam logic [23:0] VEC [9] = '{
    {8'h01, 16'd22935}, {8'h08, 16'd11464}, {8'h09, 16'd10215},
    {8'h0F, 16'd5740},  {8'h10, 16'd5107},  {8'h15, 16'd3036},
    {8'h00, 16'd0},     {8'h16, 16'd0},     {8'hFF, 16'd0}
  };

  function automatic int exp_half(input int code);
    case (code)
      1: return 22935 >> SHIFT;
      8: return 11464 >> SHIFT;
      9: return 10215 >> SHIFT;
      15: return 5740 >> SHIFT;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_melody(input int i);
    int lo;
    lo = i % 8;
    return ((i / 8) % 2 == 1) ? 15 - lo : 8 + lo;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  // Cycles between two successive buzzer toggles; 0 if no toggle appears.
  task automatic measure(output int n);
    logic prev;
    int w;
    n = 0;
    prev = buzzer;
    w = 0;
    while (buzzer == prev && w < LIMIT) begin @(negedge clk); w++; end
    if (w >= LIMIT) return;
    prev = buzzer;
    w = 0;
    while (buzzer == prev && w < LIMIT) begin @(negedge clk); w++; end
    n = (w >= LIMIT) ? 0 : w;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int cyc0;
    int steps [8] = '{0, 1, 7, 8, 15, 63, 64, 65};

    repeat (5) @(negedge clk);
    check("R1 buzzer in reset", int'(buzzer), 0);
    check("R1 refresh in reset", int'(refresh_en), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 buzzer after reset", int'(buzzer), 0);
    check("R1 refresh after reset", int'(refresh_en), 1);

    measure(n);
    check("R9 idle buzzer", n, 0);

    // Stream table, window closed
    foreach (VEC[k]) begin
      send_byte(VEC[k][23:16]);
      check("R6 refresh low on stream", int'(refresh_en), 0);
      measure(n);
      check($sformatf("R3 R5 code %02h", VEC[k][23:16]), n, int'(VEC[k][15:0]) >> SHIFT);
    end

    // Idle timeout
    send_byte(8'h08);
    repeat (IDLE - 1) @(posedge clk);
    @(negedge clk);
    check("R7 refresh just before timeout", int'(refresh_en), 0);
    @(negedge clk);
    check("R7 refresh at timeout", int'(refresh_en), 1);
    repeat (5) @(negedge clk);
    measure(n);
    check("R7 R9 quiet after stream", n, 0);

    // Window boundaries
    min_tens = 4'd0; min_ones = 4'd0; sec_tens = 4'd3;
    repeat (3) @(negedge clk);
    measure(n);
    check("R2 sec_tens 3 silent", n, 0);
    min_ones = 4'd1; sec_tens = 4'd0;
    repeat (3) @(negedge clk);
    measure(n);
    check("R2 min_ones 1 silent", n, 0);
    min_tens = 4'd1; min_ones = 4'd0;
    repeat (3) @(negedge clk);
    measure(n);
    check("R2 min_tens 1 silent", n, 0);

    // Priority: stream over open window
    min_tens = 4'd0;
    send_byte(8'h01);
    measure(n);
    check("R8 stream wins over chime", n, exp_half(1));
    check("R8 refresh low", int'(refresh_en), 0);
    min_tens = 4'd1;
    repeat (IDLE + 10) @(negedge clk);

    // Melody sequence and wrap
    min_tens = 4'd0; min_ones = 4'd0; sec_tens = 4'd2;
    cyc0 = cyc;
    foreach (steps[k]) begin
      while (cyc < cyc0 + steps[k] * STEP + 300) @(negedge clk);
      measure(n);
      check($sformatf("R4 melody step %0d", steps[k]), n, exp_half(exp_melody(steps[k])));
    end
    check("R2 refresh during chime", int'(refresh_en), 1);

    // Enable low mutes the stream
    en = 1'b0;
    send_byte(8'h08);
    measure(n);
    check("R9 en low buzzer", n, 0);
    check("R6 en low refresh", int'(refresh_en), 0);
    en = 1'b1;
    min_tens = 4'd1;

    // Reset in the middle of playback
    send_byte(8'h0F);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mid reset refresh", int'(refresh_en), 1);
    check("R1 mid reset buzzer", int'(buzzer), 0);
    measure(n);
    check("R1 R9 quiet after mid reset", n, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule